// File: doc/BRIEF.md
# Four-Phase Signal Head Sequencer

This block steps a single signal head through four lamp phases: green, yellow, red, and red shown together with yellow. It moves forward by one phase on each clock in which the advance strobe is high, and stays where it is otherwise. Phase durations are not timed here. An external timer or controller owns them and raises the strobe when a phase should end.

A compile-time parameter picks how the state is stored:
- a 2-bit binary count;
- a 4-bit one-hot vector;
- a 3-bit output-encoded word, in which each state bit drives one lamp directly.

The machine is a Moore machine, so the lamps depend only on the stored state. All three variants therefore give the same lamp waveform, cycle for cycle.

The lamps come out as a 3-bit vector. The raw state code also comes out, zero-extended to 4 bits, so it can be observed. Both the advance strobe and the reset are plain control pins and have no handshake.

Top module: `lamp_phase_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the block enters the red phase after that edge, whatever `adv` is.
- R2: When `adv` is high at a rising edge and `rst` is low, the phase after the edge follows the order green → yellow → red → red+yellow → green.
- R3: When `adv` and `rst` are both low at a rising edge, neither `lamps` nor `state_code` changes.
- R4: `lamps` bit 0 is green, bit 1 is yellow and bit 2 is red. The four phases show the following values:
  - green: 001
  - yellow: 010
  - red: 100
  - red+yellow: 110
- R5: With the binary encoding, `state_code[1:0]` holds a code for each phase and `state_code[3:2]` is 0. The codes are:
  - green: 00
  - yellow: 01
  - red: 10
  - red+yellow: 11
- R6: With the one-hot encoding, `state_code` holds one of the following codes:
  - green: 0001
  - yellow: 0010
  - red: 0100
  - red+yellow: 1000
- R7: With the one-hot encoding, a state vector that does not have exactly one bit set returns to red (0100) on the next clock. In normal operation the vector always has exactly one bit set.
- R8: With the output encoding, `state_code[2:0]` equals `lamps` and `state_code[3]` is 0.
- R9: Driven by the same `rst` and `adv`, the three encodings produce identical `lamps` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; forces the red phase |
| adv | input | 1 | Phase-advance strobe, sampled at each rising edge |
| lamps | output | 3 | Lamp drives: bit 2 red, bit 1 yellow, bit 0 green |
| state_code | output | 4 | Current state code, zero-extended to 4 bits |

## Verification
Every output comes from a register, so a change on `rst` or `adv` at one rising edge shows up on `lamps` and `state_code` exactly one clock later. No combinational path from the inputs exists.

The bench drives inputs on the falling edge. It updates its arithmetic phase model right after the following rising edge, and compares all outputs 1 ns after that edge. Each check therefore looks at the first value produced by the stimulus and at nothing later.

Three instances, one per encoding, share the stimulus. They are compared against the model and against one another on every cycle. The stimulus includes held strobes, runs of advances and resets that arrive with the strobe high.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    ENC_BINARY = 2'd0,
    ENC_ONEHOT = 2'd1,
    ENC_OUTPUT = 2'd2
  } enc_e;

  localparam int NUM_PHASES = 4;
  localparam int LAMP_W     = 3;
  localparam int CODE_W     = NUM_PHASES;
  localparam int BIN_W      = $clog2(NUM_PHASES);

  localparam logic [LAMP_W-1:0] LAMP_GREEN  = 3'b001;
  localparam logic [LAMP_W-1:0] LAMP_YELLOW = 3'b010;
  localparam logic [LAMP_W-1:0] LAMP_RED    = 3'b100;
  localparam logic [LAMP_W-1:0] LAMP_REDYEL = 3'b110;

  function automatic logic [LAMP_W-1:0] lamp_after(input logic [LAMP_W-1:0] cur);
    case (cur)
      LAMP_GREEN:  lamp_after = LAMP_YELLOW;
      LAMP_YELLOW: lamp_after = LAMP_RED;
      LAMP_RED:    lamp_after = LAMP_REDYEL;
      default:     lamp_after = LAMP_GREEN;
    endcase
  endfunction
endpackage

// File: rtl/lps_core_binary.sv
module lps_core_binary
  import lps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [BIN_W-1:0]  code,
  output logic [LAMP_W-1:0] lamps
);
  localparam logic [BIN_W-1:0] CODE_RED = BIN_W'(2);

  logic [BIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= CODE_RED;
    else if (adv) cnt_q <= cnt_q + 1'b1;
  end

  // decode: count 0 green, 1 yellow, 2 red, 3 red+yellow
  always_comb begin
    lamps[0] = (cnt_q == '0);
    lamps[1] = cnt_q[0];
    lamps[2] = cnt_q[1];
  end

  assign code = cnt_q;
endmodule

// File: rtl/lps_core_onehot.sv
module lps_core_onehot
  import lps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [CODE_W-1:0] code,
  output logic [LAMP_W-1:0] lamps
);
  localparam logic [CODE_W-1:0] HOT_RED = CODE_W'(1) << 2;

  logic [CODE_W-1:0] hot_q;
  logic              legal;

  assign legal = $onehot(hot_q);

  always_ff @(posedge clk) begin
    if (rst || !legal) hot_q <= HOT_RED;
    else if (adv)      hot_q <= {hot_q[CODE_W-2:0], hot_q[CODE_W-1]};
  end

  // one OR gate per lamp; red+yellow lights both
  always_comb begin
    lamps[0] = hot_q[0];
    lamps[1] = hot_q[1] | hot_q[3];
    lamps[2] = hot_q[2] | hot_q[3];
  end

  assign code = hot_q;
endmodule

// File: rtl/lps_core_outenc.sv
module lps_core_outenc
  import lps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LAMP_W-1:0] code,
  output logic [LAMP_W-1:0] lamps
);
  logic [LAMP_W-1:0] st_q;
  logic [LAMP_W-1:0] st_next;

  always_comb begin
    case (st_q)
      LAMP_GREEN:  st_next = LAMP_YELLOW;
      LAMP_YELLOW: st_next = LAMP_RED;
      LAMP_RED:    st_next = LAMP_REDYEL;
      LAMP_REDYEL: st_next = LAMP_GREEN;
      default:     st_next = LAMP_RED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      st_q <= LAMP_RED;
    else if (adv) st_q <= st_next;
  end

  // state bits are the lamp drives
  assign lamps = st_q;
  assign code  = st_q;
endmodule

// File: rtl/lamp_phase_seq.sv
module lamp_phase_seq
  import lps_pkg::*;
#(
  parameter lps_pkg::enc_e ENC = lps_pkg::ENC_BINARY
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adv,
  output logic [2:0]  lamps,
  output logic [3:0]  state_code
);
  generate
    if (ENC == ENC_ONEHOT) begin : g_onehot
      logic [CODE_W-1:0] c;
      lps_core_onehot u_core (
        .clk(clk), .rst(rst), .adv(adv), .code(c), .lamps(lamps)
      );
      assign state_code = c;
    end else if (ENC == ENC_OUTPUT) begin : g_outenc
      logic [LAMP_W-1:0] c;
      lps_core_outenc u_core (
        .clk(clk), .rst(rst), .adv(adv), .code(c), .lamps(lamps)
      );
      assign state_code = {{(CODE_W-LAMP_W){1'b0}}, c};
    end else begin : g_binary
      logic [BIN_W-1:0] c;
      lps_core_binary u_core (
        .clk(clk), .rst(rst), .adv(adv), .code(c), .lamps(lamps)
      );
      assign state_code = {{(CODE_W-BIN_W){1'b0}}, c};
    end
  endgenerate
endmodule

// File: rtl/lps_checker.sv
module lps_checker
  import lps_pkg::*;
#(
  parameter lps_pkg::enc_e ENC = lps_pkg::ENC_BINARY
) (
  input logic       clk,
  input logic       rst,
  input logic       adv,
  input logic [2:0] lamps,
  input logic [3:0] state_code
);
  a_r1_reset_red: assert property (@(posedge clk)
    rst |=> lamps == LAMP_RED);

  a_r2_advance_order: assert property (@(posedge clk) disable iff (rst)
    adv |=> lamps == lamp_after($past(lamps)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(lamps) && $stable(state_code));

  a_r4_legal_lamps: assert property (@(posedge clk) disable iff (rst)
    lamps == LAMP_GREEN || lamps == LAMP_YELLOW ||
    lamps == LAMP_RED   || lamps == LAMP_REDYEL);

  generate
    if (ENC == ENC_ONEHOT) begin : g_oh
      a_r6_onehot_code: assert property (@(posedge clk) disable iff (rst)
        $onehot(state_code));
      a_r7_onehot_recover: assert property (@(posedge clk) disable iff (rst)
        !$onehot(state_code) |=> state_code == 4'b0100);
    end else if (ENC == ENC_OUTPUT) begin : g_oe
      a_r8_code_is_lamps: assert property (@(posedge clk) disable iff (rst)
        state_code == {1'b0, lamps});
    end else begin : g_bin
      a_r5_binary_upper_zero: assert property (@(posedge clk) disable iff (rst)
        state_code[3:2] == 2'b00);
    end
  endgenerate
endmodule

bind lamp_phase_seq lps_checker #(.ENC(ENC)) u_lps_checker (
  .clk(clk), .rst(rst), .adv(adv), .lamps(lamps), .state_code(state_code)
);

// File: tb/test_lamp_phase_seq.sv
`timescale 1ns/1ps
module test_lamp_phase_seq;
  import lps_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv = 1'b0;
  logic [2:0] lamps_b, lamps_h, lamps_o;
  logic [3:0] code_b, code_h, code_o;

  int checks = 0;
  int fails  = 0;
  int ph     = 2;

  always #2 clk = ~clk;

  lamp_phase_seq #(.ENC(ENC_BINARY)) i_lamp_phase_seq (
    .clk(clk), .rst(rst), .adv(adv), .lamps(lamps_b), .state_code(code_b));
  lamp_phase_seq #(.ENC(ENC_ONEHOT)) i_lamp_phase_seq_oh (
    .clk(clk), .rst(rst), .adv(adv), .lamps(lamps_h), .state_code(code_h));
  lamp_phase_seq #(.ENC(ENC_OUTPUT)) i_lamp_phase_seq_oe (
    .clk(clk), .rst(rst), .adv(adv), .lamps(lamps_o), .state_code(code_o));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_lamps(input int p);
    return {p[1], p[0], (p == 0)};
  endfunction

  task automatic step(input logic r, input logic a);
    string tag;
    @(negedge clk);
    rst = r;
    adv = a;
    @(posedge clk);
    #1;
    if (r)      ph = 2;
    else if (a) ph = (ph + 1) % 4;
    tag = r ? "R1" : (a ? "R2" : "R3");
    chk({tag, " lamps"}, {1'b0, lamps_b}, {1'b0, exp_lamps(ph)});
    chk("R4 lamp map", {1'b0, lamps_o}, {1'b0, exp_lamps(ph)});
    chk("R5 binary code", code_b, 4'(ph));
    chk("R6 onehot code", code_h, 4'(1) << ph);
    chk("R7 onehot single bit", 4'($countones(code_h)), 4'd1);
    chk("R8 output code", code_o, {1'b0, lamps_o});
    chk("R9 onehot lamps equal", {1'b0, lamps_h}, {1'b0, lamps_b});
    chk("R9 outenc lamps equal", {1'b0, lamps_o}, {1'b0, lamps_b});
  endtask

  initial begin
    #(4.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // sweep every phase with hold and advance
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
    end
    for (int k = 0; k < 12; k++) step(1'b0, 1'b1);
    // reset from each phase, strobe high
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < p + 1; k++) step(1'b0, 1'b1);
      step(1'b1, 1'b1);
    end
    // arithmetic pseudo-random pattern
    for (int i = 0; i < 3000; i++) begin
      step((i % 211) == 100, ((i * 13 + i / 7) % 5) < 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule